// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight external inputs and turns each one into a clean, debounced level. Each input has its own filter time, counted in millisecond ticks taken from a strobe input. When the filtered level of an input matches the polarity that software chose for it, and that input has been armed, the block latches a status bit. It can then raise one combined interrupt line.

Detection is single-shot. A firing input disarms itself, and it cannot fire again until software clears its status bit and arms it again. Software reaches the bank through a simple 32-bit register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is registered and appears one cycle after `reg_addr` is presented.

Top module: `lvl_irq_bank`

## Requirements
- R1: After reset every register reads zero, every input is disarmed and `irq` is low.
- R2: The level register at 0x00 returns bit n as the debounced level of input n only while bit n of the level-enable register at 0x04 is 1; otherwise bit n reads 0.
- R3: The debounce time of input n is held in bits [11:0] of the register at 0x40 + 4*n, which reads back its value. The debounced level takes the new raw value only on the tick where the raw input has differed for that many ticks. Any return to the old value before then restarts the count, and the level never changes in a cycle that follows a cycle without a tick.
- R4: A debounce time of 0 behaves as a time of 1 tick.
- R5: In the polarity register at 0x14, bit n = 1 makes input n active when its debounced level is 1, and bit n = 0 makes it active when the level is 0. An armed and active input sets its bit in the raw status register at 0x1C.
- R6: Writing 1 to bit n of the arm register at 0x28 arms input n, and reading 0x28 returns the armed set. When an input fires, its arm bit clears in the same cycle that its status bit sets. An unarmed input never sets a status bit, even while it stays active.
- R7: Writing 1 to bit n of the clear register at 0x24 clears raw status bit n. A written 0 leaves that bit unchanged.
- R8: The masked status register at 0x20 reads as raw status ANDed with the enable register at 0x18.
- R9: `irq` is the OR of all masked status bits, registered one cycle after them, and it is never high unless some enable bit was set in the cycle before.
- R10: Unmapped offsets read 0, and writes to the level, raw status and masked status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| pin_in | input | 8 | Raw external inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed patterns come first, each chosen to separate one behaviour from a near neighbour:
- A pulse one tick shorter than the programmed time, followed by a glitch back to the old value, tells a restarting counter from one that merely pauses.
- A zero debounce time tells the one-tick minimum apart from a filter that is stuck.
- An active input that is not armed separates level-following status from single-shot status.
- A clear written while the input stays active shows that the status bit does not set again without re-arming.

Random sequences then mix sparse input toggles with arm, clear, polarity, enable and short debounce-time writes. Each register and the interrupt line are compared with a tick-level model after every operation.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned DATA_W = 32;

  // register offsets; the bus side decodes these
  localparam int unsigned OFS_LEVEL  = 'h00;
  localparam int unsigned OFS_LVLEN  = 'h04;
  localparam int unsigned OFS_POL    = 'h14;
  localparam int unsigned OFS_IE     = 'h18;
  localparam int unsigned OFS_RAW    = 'h1C;
  localparam int unsigned OFS_MASKED = 'h20;
  localparam int unsigned OFS_CLR    = 'h24;
  localparam int unsigned OFS_ARM    = 'h28;
  localparam int unsigned OFS_DBT    = 'h40;
  localparam int unsigned DBT_STRIDE = 4;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_filter.sv
module lvl_irq_filter #(
  parameter int unsigned DBT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             din,
  input  logic [DBT_W-1:0] limit,
  output logic             level
);
  logic [DBT_W-1:0] cnt_q;
  logic [DBT_W-1:0] lim_eff;
  logic [DBT_W:0]   cnt_inc;

  // zero time means one tick
  assign lim_eff = (limit == '0) ? DBT_W'(1) : limit;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      level <= 1'b0;
    end else if (din == level) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, lim_eff}) begin
        level <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[DBT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_status.sv
module lvl_irq_status #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] level,
  input  logic [N_IN-1:0] pol,
  input  logic [N_IN-1:0] ie,
  input  logic [N_IN-1:0] arm_set,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] raw,
  output logic [N_IN-1:0] arm,
  output logic [N_IN-1:0] masked,
  output logic            irq
);
  logic [N_IN-1:0] active;
  logic [N_IN-1:0] fire;

  assign active = ~(level ^ pol);
  assign fire   = arm & active;
  assign masked = raw & ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      arm <= '0;
      irq <= 1'b0;
    end else begin
      raw <= (raw & ~clr) | fire;
      arm <= (arm | arm_set) & ~fire;
      irq <= |masked;
    end
  end
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned DBT_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [N_IN-1:0]             level,
  input  logic [N_IN-1:0]             raw,
  input  logic [N_IN-1:0]             arm,
  input  logic [N_IN-1:0]             masked,
  output logic [N_IN-1:0]             lvl_en,
  output logic [N_IN-1:0]             pol,
  output logic [N_IN-1:0]             ie,
  output logic [N_IN-1:0][DBT_W-1:0]  dbt,
  output logic [N_IN-1:0]             arm_set,
  output logic [N_IN-1:0]             clr
);
  logic [N_IN-1:0]   wd;
  logic [DATA_W-1:0] rd_mux;

  assign wd      = reg_wdata[N_IN-1:0];
  assign arm_set = (reg_wr && reg_addr == ADDR_W'(OFS_ARM)) ? wd : '0;
  assign clr     = (reg_wr && reg_addr == ADDR_W'(OFS_CLR)) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_en <= '0;
      pol    <= '0;
      ie     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(OFS_LVLEN)) lvl_en <= wd;
      if (reg_addr == ADDR_W'(OFS_POL))   pol    <= wd;
      if (reg_addr == ADDR_W'(OFS_IE))    ie     <= wd;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_dbt
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS_DBT + DBT_STRIDE * i);
    always_ff @(posedge clk) begin
      if (rst)                               dbt[i] <= '0;
      else if (reg_wr && reg_addr == MY_OFS) dbt[i] <= reg_wdata[DBT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      ADDR_W'(OFS_LEVEL):  rd_mux[N_IN-1:0] = level & lvl_en;
      ADDR_W'(OFS_LVLEN):  rd_mux[N_IN-1:0] = lvl_en;
      ADDR_W'(OFS_POL):    rd_mux[N_IN-1:0] = pol;
      ADDR_W'(OFS_IE):     rd_mux[N_IN-1:0] = ie;
      ADDR_W'(OFS_RAW):    rd_mux[N_IN-1:0] = raw;
      ADDR_W'(OFS_MASKED): rd_mux[N_IN-1:0] = masked;
      ADDR_W'(OFS_ARM):    rd_mux[N_IN-1:0] = arm;
      default: begin
        for (int i = 0; i < N_IN; i++) begin
          if (reg_addr == ADDR_W'(OFS_DBT + DBT_STRIDE * i)) rd_mux[DBT_W-1:0] = dbt[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IN        = 8,
  parameter int unsigned DBT_W       = 12,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [N_IN-1:0]   pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic [N_IN-1:0]            pin_s;
  logic [N_IN-1:0]            level_q;
  logic [N_IN-1:0]            raw_q;
  logic [N_IN-1:0]            arm_q;
  logic [N_IN-1:0]            masked;
  logic [N_IN-1:0]            lvl_en_q;
  logic [N_IN-1:0]            pol_q;
  logic [N_IN-1:0]            ie_q;
  logic [N_IN-1:0][DBT_W-1:0] dbt_q;
  logic [N_IN-1:0]            arm_set;
  logic [N_IN-1:0]            clr;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    lvl_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pin_in[i]),
      .dout(pin_s[i])
    );
    lvl_irq_filter #(.DBT_W(DBT_W)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .tick (ms_tick),
      .din  (pin_s[i]),
      .limit(dbt_q[i]),
      .level(level_q[i])
    );
  end

  lvl_irq_status #(.N_IN(N_IN)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .level  (level_q),
    .pol    (pol_q),
    .ie     (ie_q),
    .arm_set(arm_set),
    .clr    (clr),
    .raw    (raw_q),
    .arm    (arm_q),
    .masked (masked),
    .irq    (irq)
  );

  lvl_irq_regs #(.N_IN(N_IN), .DBT_W(DBT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .level    (level_q),
    .raw      (raw_q),
    .arm      (arm_q),
    .masked   (masked),
    .lvl_en   (lvl_en_q),
    .pol      (pol_q),
    .ie       (ie_q),
    .dbt      (dbt_q),
    .arm_set  (arm_set),
    .clr      (clr)
  );
endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ms_tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic [N_IN-1:0]   raw,
  input logic [N_IN-1:0]   arm,
  input logic [N_IN-1:0]   ie,
  input logic [N_IN-1:0]   level
);
  AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(ms_tick) |-> $stable(level)); // R3

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    (raw & ~$past(raw) & ~$past(arm)) == '0); // R6

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (raw & ~$past(raw) & arm) == '0); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == ADDR_W'(OFS_CLR)) |->
      ((raw & $past(reg_wdata[N_IN-1:0]) & ~$past(arm)) == '0)); // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ie) != '0)); // R9
endmodule

bind lvl_irq_bank lvl_irq_bank_chk #(.N_IN(N_IN), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ms_tick  (ms_tick),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq      (irq),
  .raw      (raw_q),
  .arm      (arm_q),
  .ie       (ie_q),
  .level    (level_q)
);

// File: tb/sim_lvl_irq_bank.sv
`timescale 1ns/1ps
module sim_lvl_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // tick-level model
  logic [7:0] pins = '0;
  logic [7:0] m_deb = '0, m_raw = '0, m_arm = '0, m_pol = '0, m_ie = '0, m_den = '0;
  int m_cnt [8];
  int m_lim [8];

  always #5 clk = ~clk;

  lvl_irq_bank u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pin_in(pin_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk) reg_addr = a;
    @(negedge clk) v = reg_rdata;
  endtask

  task automatic settle();
    logic [7:0] fire;
    fire  = m_arm & ~(m_deb ^ m_pol);
    m_raw = m_raw | fire;
    m_arm = m_arm & ~fire;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk) reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    case (a)
      8'h04: m_den = d[7:0];
      8'h14: m_pol = d[7:0];
      8'h18: m_ie  = d[7:0];
      8'h24: m_raw = m_raw & ~d[7:0];
      8'h28: m_arm = m_arm | d[7:0];
      default: if (a >= 8'h40 && a < 8'h60 && a[1:0] == 2'b00)
        m_lim[(a - 8'h40) >> 2] = (d[11:0] == 0) ? 1 : int'(d[11:0]);
    endcase
    settle();
  endtask

  task automatic step(input logic [7:0] p);
    pins = p;
    @(negedge clk) pin_in = p;
    repeat (3) @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      if (pins[n] != m_deb[n]) begin
        m_cnt[n]++;
        if (m_cnt[n] >= m_lim[n]) begin
          m_deb[n] = pins[n];
          m_cnt[n] = 0;
        end
      end else begin
        m_cnt[n] = 0;
      end
    end
    settle();
  endtask

  task automatic check_model(input string ctx);
    logic [31:0] v;
    rd(8'h00, v); chk({ctx, " R2 level"}, v, {24'h0, m_deb & m_den});
    rd(8'h1C, v); chk({ctx, " R5 raw"}, v, {24'h0, m_raw});
    rd(8'h20, v); chk({ctx, " R8 masked"}, v, {24'h0, m_raw & m_ie});
    rd(8'h28, v); chk({ctx, " R6 arm"}, v, {24'h0, m_arm});
    chk({ctx, " R9 irq"}, {31'h0, irq}, {31'h0, |(m_raw & m_ie)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < 8; n++) begin m_cnt[n] = 0; m_lim[n] = 1; end
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 level", v, 0);
    rd(8'h14, v); chk("R1 pol", v, 0);
    rd(8'h1C, v); chk("R1 raw", v, 0);
    rd(8'h28, v); chk("R1 arm", v, 0);
    rd(8'h40, v); chk("R1 dbt0", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R10 unmapped and read-only offsets
    rd(8'h30, v); chk("R10 unmapped", v, 0);
    wr(8'h1C, 32'hFF);
    rd(8'h1C, v); chk("R10 raw write ignored", v, 0);

    // R3 restart on glitch
    wr(8'h04, 32'hFF);
    wr(8'h40, 32'h3);
    rd(8'h40, v); chk("R3 dbt readback", v, 32'h3);
    step(8'h01); step(8'h01);
    rd(8'h00, v); chk("R3 two ticks short", v, 32'h00);
    step(8'h00);
    step(8'h01); step(8'h01);
    rd(8'h00, v); chk("R3 restart after glitch", v, 32'h00);
    step(8'h01);
    rd(8'h00, v); chk("R3 third tick", v, 32'h01);

    // R4 zero time acts as one tick
    step(8'h03);
    rd(8'h00, v); chk("R4 one tick", v, 32'h03);

    // R2 enable gating
    wr(8'h04, 32'h01);
    rd(8'h00, v); chk("R2 gated", v, 32'h01);
    wr(8'h04, 32'hFF);

    // R5 R6 R8 R9 single shot, active high
    wr(8'h14, 32'h02);
    rd(8'h1C, v); chk("R6 unarmed no fire", v, 32'h00);
    wr(8'h28, 32'h02);
    rd(8'h1C, v); chk("R5 active-high fire", v, 32'h02);
    rd(8'h28, v); chk("R6 disarmed", v, 32'h00);
    rd(8'h20, v); chk("R8 masked off", v, 32'h00);
    wr(8'h18, 32'h02);
    rd(8'h20, v); chk("R8 masked on", v, 32'h02);
    chk("R9 irq high", {31'h0, irq}, 1);
    wr(8'h24, 32'h00);
    rd(8'h1C, v); chk("R7 zero clear", v, 32'h02);
    wr(8'h24, 32'h02);
    rd(8'h1C, v); chk("R7 clear / R6 no refire", v, 32'h00);
    chk("R9 irq low", {31'h0, irq}, 0);
    wr(8'h28, 32'h02);
    rd(8'h1C, v); chk("R6 re-arm fires", v, 32'h02);

    // R5 active low, and an inactive armed input
    wr(8'h28, 32'h04);
    rd(8'h1C, v); chk("R5 active-low fire", v, 32'h06);
    wr(8'h28, 32'h01);
    rd(8'h1C, v); chk("R5 inactive stays", v, 32'h06);
    rd(8'h28, v); chk("R6 arm held", v, 32'h01);
    check_model("directed");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0, 1, 2, 3: step(pins ^ (8'($urandom) & 8'($urandom)));
        4: wr(8'h28, {24'h0, 8'($urandom)});
        5: wr(8'h24, {24'h0, 8'($urandom)});
        6: wr(8'h14, {24'h0, 8'($urandom)});
        7: wr(8'h40 + 8'(4 * ($urandom % 8)), 32'($urandom % 4));
        8: wr(8'h18, {24'h0, 8'($urandom)});
        default: wr(8'h04, {24'h0, 8'($urandom)});
      endcase
      check_model("random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule